// File: doc/BRIEF.md
# Clock-Recovery Lock Source Controller

This block chooses the reference that a receive clock-recovery loop should follow. When the incoming stream looks like valid data at the right rate, the block selects lock-to-data. Otherwise it selects lock-to-reference, so that the oscillator stays near the target rate when no usable signal is present. It watches the 10-bit parallel words that arrive on the recovered word clock, and it measures how many recovered clock cycles occur in a fixed number of reference clock cycles.

There are two tests. The run-length test flags a stream that is stuck: it fires when a number of consecutive whole words (12 by default) are all zeros, or all ones. The rate test counts recovered cycles over a window of reference cycles and compares the total with a nominal value, within a tolerance given in ppm. The reference may run at the word rate or at half of it. `clksel_i` selects which, and the nominal count is scaled to match. The recovered word clock is always at the word rate.

The select output rises only at the end of a measurement window in which both tests passed. A run-length violation drops it at once. A rate failure drops it at the end of the window that measured it. Two sticky status flags report which test failed.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While `rst_ni` is low, `lock_data_o`, `run_len_fail_o` and `freq_fail_o` are all 0, and they go to 0 as soon as reset is asserted.
- R2: A word is classed as all-zero when every bit is 0 and as all-one when every bit is 1. A run-length violation occurs when `RUN_WORDS` consecutive words are all-zero, or are all-one. `RUN_WORDS`-1 such words, or a mix of all-zero and all-one words, cause no violation.
- R3: A run-length violation drives `lock_data_o` to 0 within 30 reference cycles of the last word of the run, at any point in the measurement window.
- R4: `run_len_fail_o` sets on a run-length violation. It then holds until the end of the first window during which no violation was seen, and clears there.
- R5: A measurement window is `WIN_CYC` reference cycles long. Windows end on every `WIN_CYC`-th rising edge of `refclk_i` after reset release. The rate test passes when the number of recovered cycles in the window differs from the nominal count by no more than round(nominal × `TOL_PPM` / 10^6).
- R6: `freq_fail_o` is loaded at each window end with the inverse of that window's rate result, and it does not change between window ends.
- R7: `lock_data_o` rises only at a window end, and only if that window passed the rate test and saw no run-length violation. A window that fails the rate test leaves `lock_data_o` at 0 after its end.
- R8: After reset release, `lock_data_o` stays 0 until the first full measurement window has ended.
- R9: The nominal count is `WIN_CYC` when `clksel_i`=0 (reference at the word rate) and 2×`WIN_CYC` when `clksel_i`=1 (reference at half the word rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk_i | input | 1 | Recovered word clock |
| refclk_i | input | 1 | Local reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| clksel_i | input | 1 | 0: reference at word rate; 1: reference at half word rate |
| word_i | input | WORD_W | Received parallel word, one per `rclk_i` cycle |
| lock_data_o | output | 1 | 1: track data; 0: track reference |
| run_len_fail_o | output | 1 | Sticky run-length failure flag |
| freq_fail_o | output | 1 | Rate test failed in the last completed window |

## Verification
The bench builds the block with `WIN_CYC`=200 and `TOL_PPM`=50000, which gives a tolerance of ±10 counts at `clksel_i`=0 and ±20 at `clksel_i`=1. With windows this short, dozens of lock, drop and relock transitions fit in a short run. Recovered periods a few percent off nominal (18.6 ns, 20.6 ns, 9 ns) then fall clearly inside or outside the window. `RUN_WORDS` stays at 12, so the bursts of 11 words, 12 words and 6+6 mixed words exercise the exact threshold of the run-length test. A behavioural model predicts the select and flag values at mid-window points from the clock period and the bursts that were injected.

// File: rtl/cdr_lock_pkg.sv
`timescale 1ns/1ps
package cdr_lock_pkg;

  typedef enum logic [1:0] {
    WCLS_MIX  = 2'd0,
    WCLS_ZERO = 2'd1,
    WCLS_ONE  = 2'd2
  } word_cls_e;

  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DATA = 1'b1
  } lock_src_e;

  // rounded tolerance in counts
  function automatic int unsigned ppm_tol(input int unsigned nom, input int unsigned ppm);
    longint unsigned p;
    p = longint'(nom) * longint'(ppm) + 64'd500000;
    return 32'(p / 64'd1000000);
  endfunction

endpackage

// File: rtl/cdr_sync.sv
`timescale 1ns/1ps
module cdr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/cdr_run_len.sv
`timescale 1ns/1ps
module cdr_run_len
  import cdr_lock_pkg::*;
#(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned RUN_WORDS = 12,
  parameter int unsigned STRETCH   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              viol_o
);

  localparam int unsigned STR_W = $clog2(STRETCH + 1);

  word_cls_e  cls;
  logic [1:0] lane_bit;
  logic [1:0] lane_full;
  logic       hit_q;
  logic [STR_W-1:0] str_q;

  always_comb begin
    if (word_i == '0)      cls = WCLS_ZERO;
    else if (word_i == '1) cls = WCLS_ONE;
    else                   cls = WCLS_MIX;
  end

  assign lane_bit = {cls == WCLS_ONE, cls == WCLS_ZERO};

  // lane 0 tracks all-zero words, lane 1 all-one words
  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [RUN_WORDS-1:0] hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= {hist_q[RUN_WORDS-2:0], lane_bit[k]};
    end
    assign lane_full[k] = &hist_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      str_q <= '0;
    end else begin
      hit_q <= |lane_full;
      if (hit_q)           str_q <= STR_W'(STRETCH);
      else if (str_q != 0) str_q <= str_q - 1'b1;
    end
  end

  // pulse stretched so a slower sampling clock cannot miss it
  assign viol_o = (str_q != '0);

  p_hit_stretch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |=> viol_o);

  p_lane_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_full));

endmodule

// File: rtl/cdr_rate_cnt.sv
`timescale 1ns/1ps
module cdr_rate_cnt #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] gray_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      gray_q <= cnt_q ^ (cnt_q >> 1);
    end
  end

  assign gray_o = gray_q;

  p_gray_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/cdr_lock_fsm.sv
`timescale 1ns/1ps
module cdr_lock_fsm
  import cdr_lock_pkg::*;
#(
  parameter int unsigned WIN_CYC = 65536,
  parameter int unsigned TOL_PPM = 200,
  parameter int unsigned CNT_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clksel_i,
  input  logic             run_viol_i,
  input  logic [CNT_W-1:0] rate_gray_i,
  output logic             lock_o,
  output logic             run_fail_o,
  output logic             freq_fail_o
);

  localparam int unsigned NOM0  = WIN_CYC;
  localparam int unsigned NOM1  = 2 * WIN_CYC;
  localparam int unsigned TOL0  = ppm_tol(NOM0, TOL_PPM);
  localparam int unsigned TOL1  = ppm_tol(NOM1, TOL_PPM);
  localparam logic [CNT_W-1:0] LO0 = CNT_W'(NOM0 - TOL0);
  localparam logic [CNT_W-1:0] HI0 = CNT_W'(NOM0 + TOL0);
  localparam logic [CNT_W-1:0] LO1 = CNT_W'(NOM1 - TOL1);
  localparam logic [CNT_W-1:0] HI1 = CNT_W'(NOM1 + TOL1);
  localparam int unsigned WIN_W = $clog2(WIN_CYC);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] win_q;
  logic             win_end;
  logic [CNT_W-1:0] rate_bin;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] delta;
  logic             freq_ok;
  logic             seen_q;
  lock_src_e        src_q;
  logic             run_fail_q;
  logic             freq_fail_q;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) rate_bin[i] = ^(rate_gray_i >> i);
  end

  assign win_end = (win_q == WIN_LAST);
  assign delta   = rate_bin - base_q;
  assign freq_ok = clksel_i ? (delta >= LO1 && delta <= HI1)
                            : (delta >= LO0 && delta <= HI0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= '0;
      base_q      <= '0;
      seen_q      <= 1'b0;
      src_q       <= SRC_REF;
      run_fail_q  <= 1'b0;
      freq_fail_q <= 1'b0;
    end else begin
      win_q  <= win_end ? '0 : win_q + 1'b1;
      seen_q <= win_end ? run_viol_i : (seen_q | run_viol_i);
      if (win_end) begin
        base_q      <= rate_bin;
        freq_fail_q <= !freq_ok;
        run_fail_q  <= seen_q | run_viol_i;
        src_q       <= (freq_ok && !seen_q && !run_viol_i) ? SRC_DATA : SRC_REF;
      end else if (run_viol_i) begin
        src_q      <= SRC_REF;
        run_fail_q <= 1'b1;
      end
    end
  end

  assign lock_o      = (src_q == SRC_DATA);
  assign run_fail_o  = run_fail_q;
  assign freq_fail_o = freq_fail_q;

  p_viol_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_viol_i |=> !lock_o);

  p_viol_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_viol_i |=> run_fail_o);

  p_freq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(win_end) |-> $stable(freq_fail_o));

  p_rise_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(win_end));

  p_freq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end && !freq_ok) |=> (!lock_o && freq_fail_o));

endmodule

// File: rtl/cdr_lock_ctrl.sv
`timescale 1ns/1ps
module cdr_lock_ctrl #(
  parameter int unsigned WORD_W      = 10,
  parameter int unsigned RUN_WORDS   = 12,
  parameter int unsigned WIN_CYC     = 65536,
  parameter int unsigned TOL_PPM     = 200,
  parameter int unsigned STRETCH     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              rclk_i,
  input  logic              refclk_i,
  input  logic              rst_ni,
  input  logic              clksel_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              lock_data_o,
  output logic              run_len_fail_o,
  output logic              freq_fail_o
);

  localparam int unsigned CNT_W = $clog2(2 * WIN_CYC) + 2;

  logic             viol_r;
  logic             viol_s;
  logic [CNT_W-1:0] gray_r;
  logic [CNT_W-1:0] gray_s;

  cdr_run_len #(
    .WORD_W   (WORD_W),
    .RUN_WORDS(RUN_WORDS),
    .STRETCH  (STRETCH)
  ) u_run_len (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .word_i(word_i),
    .viol_o(viol_r)
  );

  cdr_rate_cnt #(.CNT_W(CNT_W)) u_rate_cnt (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_o(gray_r)
  );

  cdr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_viol (
    .clk_i (refclk_i),
    .rst_ni(rst_ni),
    .d_i   (viol_r),
    .q_o   (viol_s)
  );

  cdr_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync_rate (
    .clk_i (refclk_i),
    .rst_ni(rst_ni),
    .d_i   (gray_r),
    .q_o   (gray_s)
  );

  cdr_lock_fsm #(
    .WIN_CYC(WIN_CYC),
    .TOL_PPM(TOL_PPM),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk_i      (refclk_i),
    .rst_ni     (rst_ni),
    .clksel_i   (clksel_i),
    .run_viol_i (viol_s),
    .rate_gray_i(gray_s),
    .lock_o     (lock_data_o),
    .run_fail_o (run_len_fail_o),
    .freq_fail_o(freq_fail_o)
  );

endmodule

// File: tb/cdr_lock_ctrl_test.sv
`timescale 1ns/1ps
module cdr_lock_ctrl_test;

  localparam int WIN = 200;
  localparam int PPM = 50000;

  logic       refclk = 1'b0;
  logic       rclk   = 1'b0;
  logic       rst_n  = 1'b0;
  logic       clksel = 1'b0;
  logic [9:0] word   = 10'h17C;
  logic       lock_data, rl_fail, f_fail;
  real        rper   = 20.0;

  int n_chk  = 0;
  int n_fail = 0;
  logic [9:0] wq[$];
  logic alt = 1'b0;

  cdr_lock_ctrl #(.WIN_CYC(WIN), .TOL_PPM(PPM)) uut (
    .rclk_i        (rclk),
    .refclk_i      (refclk),
    .rst_ni        (rst_n),
    .clksel_i      (clksel),
    .word_i        (word),
    .lock_data_o   (lock_data),
    .run_len_fail_o(rl_fail),
    .freq_fail_o   (f_fail)
  );

  always #10 refclk = ~refclk;
  always #(rper / 2.0) rclk = ~rclk;

  // normal traffic alternates two mixed-bit words; queued bursts take priority
  always @(negedge rclk) begin
    if (wq.size() > 0) word <= wq.pop_front();
    else begin
      word <= alt ? 10'h17C : 10'h283;
      alt  <= ~alt;
    end
  end

  // behavioural rate model: R5, R9
  function automatic logic rate_ok(real per, logic sel);
    real cnt, nom, tol;
    cnt = WIN * 20.0 / per;
    nom = sel ? 2.0 * WIN : 1.0 * WIN;
    tol = $floor(nom * PPM / 1.0e6 + 0.5);
    return (cnt >= nom - tol) && (cnt <= nom + tol);
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic expect_all(string req, logic lk, logic rl, logic ff);
    check(req, "lock_data_o", lock_data, lk);
    check(req, "run_len_fail_o", rl_fail, rl);
    check(req, "freq_fail_o", f_fail, ff);
  endtask

  task automatic wait_ref(int n);
    repeat (n) @(negedge refclk);
  endtask

  task automatic push_run(logic [9:0] v, int n);
    for (int i = 0; i < n; i++) wq.push_back(v);
  endtask

  // burst at mid-window, expect drop, flag held one window, relock after clean window
  task automatic viol_cycle(string req, logic [9:0] v);
    push_run(v, 12);
    wait_ref(30);
    check(req, "drop lock_data_o", lock_data, 1'b0);
    check(req, "set run_len_fail_o", rl_fail, 1'b1);
    wait_ref(WIN - 30);
    check("R4", "held run_len_fail_o", rl_fail, 1'b1);
    check("R7", "no relock in dirty window", lock_data, 1'b0);
    wait_ref(WIN);
    check("R4", "cleared run_len_fail_o", rl_fail, 1'b0);
    check("R7", "relock after clean window", lock_data, 1'b1);
  endtask

  task automatic no_viol(string req);
    wait_ref(30);
    check(req, "lock kept", lock_data, 1'b1);
    check(req, "no run flag", rl_fail, 1'b0);
    wait_ref(WIN - 30);
    expect_all(req, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic rate_step(string req, real per, logic sel);
    logic ok;
    rper   = per;
    clksel = sel;
    ok     = rate_ok(per, sel);
    wait_ref(2 * WIN);
    expect_all(req, ok, 1'b0, !ok);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge refclk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    wait_ref(5);
    expect_all("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_ref(WIN / 2);
    check("R8", "no lock before first window", lock_data, 1'b0);
    wait_ref(WIN);
    expect_all("R7", rate_ok(20.0, 1'b0), 1'b0, !rate_ok(20.0, 1'b0));

    viol_cycle("R3", 10'h000);
    viol_cycle("R2", 10'h3FF);

    push_run(10'h000, 11);
    no_viol("R2");
    push_run(10'h000, 6);
    push_run(10'h3FF, 6);
    no_viol("R2");

    rate_step("R5", 18.6, 1'b0);
    rate_step("R6", 20.6, 1'b0);
    rate_step("R9", 20.0, 1'b1);
    rate_step("R9", 10.0, 1'b1);

    viol_cycle("R3", 10'h3FF);

    rate_step("R5", 9.0, 1'b1);
    wait_ref(50);
    check("R6", "freq_fail_o held mid-window", f_fail, 1'b1);
    wait_ref(WIN - 50);

    rate_step("R7", 10.0, 1'b1);
    rst_n = 1'b0;
    wait_ref(1);
    expect_all("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_ref(WIN / 2);
    check("R8", "no lock before first window after reset", lock_data, 1'b0);
    wait_ref(WIN);
    expect_all("R8", 1'b1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule